// File: doc/BRIEF.md
# Boot Source and Flash Partition Decoder

This block turns a small set of non-volatile configuration options into the decisions a microcontroller needs right after reset. These decisions are where to fetch the first instruction, which partition a given program-space address belongs to, whether a self-programming write may proceed, and what an external programmer sees when it dumps code. The program space is 64 KB. It is split into three contiguous partitions: application (AP) at the bottom, an optional in-application-programming (IAP) area above it, and an optional in-system-programming (ISP) loader area at the top.

The configuration (option bits, ISP start address, IAP lower bound and the cause of the reset) is captured once, shortly after reset is released, and is then held until the next reset. While reset is active, and until the capture happens, the block behaves as a freshly erased part: every option is off and neither the ISP nor the IAP partition exists. Address classification, boot choice, write gating and dump masking are combinational functions of the captured configuration and the live request inputs.

Top module: `fuse_boot_ctrl`

## Requirements
- R1: While reset is active and before the configuration is captured, `boot_isp_o` is 0, every address is classified AP, and `dump_o` equals `dump_byte_i`, whatever the configuration inputs hold.
- R2: The configuration inputs are captured exactly once, within three rising clock edges after `rst_n` is released. Later changes on `opt_i`, `isp_start_i`, `iap_low_i` or `pwr_on_rst_i` have no effect until the next reset.
- R3: An ISP partition exists only when the ISP start is neither 0x0000 nor 0xFFFF. When it exists, every address at or above the start is classified ISP (code 2'b10).
- R4: An IAP partition exists when the IAP lower bound is not 0xFFFF and lies below the IAP ceiling. The ceiling is the ISP start when an ISP partition exists, and 0x10000 otherwise. Addresses from the lower bound up to, but not including, the ceiling are classified IAP (code 2'b01).
- R5: All remaining addresses are classified AP (code 2'b00). The code 2'b11 never appears.
- R6: With the any-reset boot option (`opt_i` bit 1) set and an ISP partition present, `boot_isp_o` is 1 for every reset cause.
- R7: With bit 1 clear and the power-up boot option (`opt_i` bit 0) set, `boot_isp_o` is 1 only when an ISP partition is present and the captured `pwr_on_rst_i` was 1.
- R8: With no ISP partition, `boot_isp_o` is 0 regardless of the options. With both boot options clear, it is also 0.
- R9: `wr_en_o` equals `wr_req_i`, except that it is forced to 0 while `low_volt_i` is 1 and the low-voltage protect option (`opt_i` bit 2) is set.
- R10: With the lock option (`opt_i` bit 4) set, `dump_o` is 0xFF for both code bytes and the device ID byte (`dump_is_id_i` = 1).
- R11: With the scramble option (`opt_i` bit 3) set and lock clear, code bytes are output XORed with the parameter `SCRAMBLE_KEY` (default 0xA5), and ID bytes pass through unchanged. Lock takes priority over scrambling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| opt_i | input | 5 | Option bits: 0 power-up boot, 1 any-reset boot, 2 low-voltage write protect, 3 scramble, 4 lock |
| isp_start_i | input | 16 | ISP partition start address |
| iap_low_i | input | 16 | IAP partition lower bound |
| pwr_on_rst_i | input | 1 | 1 when the current reset came from power-up |
| low_volt_i | input | 1 | Supply below the write-safe level |
| wr_req_i | input | 1 | IAP/ISP flash write request |
| addr_i | input | 16 | Address to classify |
| dump_byte_i | input | 8 | Raw byte on the programmer read-out path |
| dump_is_id_i | input | 1 | 1 when the read-out byte is the device ID |
| boot_isp_o | output | 1 | 1 to boot from the ISP partition, 0 for AP |
| region_o | output | 2 | Partition of `addr_i`: 00 AP, 01 IAP, 10 ISP |
| wr_en_o | output | 1 | Gated flash write enable |
| dump_o | output | 8 | Read-out byte after lock and scramble |

## Verification
The assertions assume that the configuration inputs stay steady from reset release until the capture edge. If they did not, the captured image would be a mix of two values. The bench holds them constant for five clock edges after release and perturbs them only afterwards, to exercise R2. The live inputs (address, write request, low-voltage flag, dump byte) are assumed to change only away from the clock edge. The bench drives them on the falling edge. Random configurations are drawn so that the ISP start is often one of the two "absent" encodings and the IAP bound often lies above the ISP start, keeping the partition-existence corner cases frequent.

// File: rtl/fbc_pkg.sv
package fbc_pkg;
  typedef enum logic [1:0] {
    PART_AP  = 2'b00,
    PART_IAP = 2'b01,
    PART_ISP = 2'b10
  } part_e;

  // packed: first member is the MSB, so lock sits at bit 4
  typedef struct packed {
    logic lock;
    logic scramble;
    logic lv_protect;
    logic boot_any;
    logic boot_pwr;
  } opt_t;

  localparam int OPT_W = 5;
endpackage

// File: rtl/fbc_rst_sync.sv
module fbc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/fbc_opt_capture.sv
module fbc_opt_capture
  import fbc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OPT_W-1:0]  opt_i,
  input  logic [ADDR_W-1:0] isp_i,
  input  logic [ADDR_W-1:0] iap_i,
  input  logic              pwr_i,
  output opt_t              opt_q,
  output logic [ADDR_W-1:0] isp_q,
  output logic [ADDR_W-1:0] iap_q,
  output logic              pwr_q,
  output logic              loaded_q
);
  logic              load_en;
  opt_t              opt_d;
  logic [ADDR_W-1:0] isp_d;
  logic [ADDR_W-1:0] iap_d;
  logic              pwr_d;
  logic              loaded_d;

  always_comb begin
    load_en  = !loaded_q;
    opt_d    = opt_q;
    isp_d    = isp_q;
    iap_d    = iap_q;
    pwr_d    = pwr_q;
    loaded_d = loaded_q;
    if (load_en) begin
      opt_d    = opt_t'(opt_i);
      isp_d    = isp_i;
      iap_d    = iap_i;
      pwr_d    = pwr_i;
      loaded_d = 1'b1;
    end
  end

  // erased image: options off, both partitions absent
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opt_q    <= '0;
      isp_q    <= '1;
      iap_q    <= '1;
      pwr_q    <= 1'b0;
      loaded_q <= 1'b0;
    end else begin
      opt_q    <= opt_d;
      isp_q    <= isp_d;
      iap_q    <= iap_d;
      pwr_q    <= pwr_d;
      loaded_q <= loaded_d;
    end
  end
endmodule

// File: rtl/fbc_region_decode.sv
module fbc_region_decode
  import fbc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] isp_start,
  input  logic [ADDR_W-1:0] iap_low,
  input  logic [ADDR_W-1:0] addr,
  output logic              isp_present,
  output logic              iap_present,
  output part_e             part
);
  localparam int EXT_W = ADDR_W + 1;
  localparam logic [EXT_W-1:0] SPACE_END = {1'b1, {ADDR_W{1'b0}}};

  logic [EXT_W-1:0] iap_ceiling;

  always_comb begin
    isp_present = (isp_start != '0) && (isp_start != '1);
    iap_ceiling = isp_present ? {1'b0, isp_start} : SPACE_END;
    iap_present = (iap_low != '1) && ({1'b0, iap_low} < iap_ceiling);
    if (isp_present && (addr >= isp_start))      part = PART_ISP;
    else if (iap_present && (addr >= iap_low))   part = PART_IAP;
    else                                         part = PART_AP;
  end
endmodule

// File: rtl/fbc_access_gate.sv
module fbc_access_gate
  import fbc_pkg::*;
#(
  parameter int          DATA_W       = 8,
  parameter logic [DATA_W-1:0] SCRAMBLE_KEY = 8'hA5
) (
  input  opt_t              opt,
  input  logic              low_volt,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              is_id,
  output logic              wr_en,
  output logic [DATA_W-1:0] byte_out
);
  always_comb begin
    wr_en = wr_req && !(opt.lv_protect && low_volt);
    if (opt.lock)                  byte_out = '1;
    else if (opt.scramble && !is_id) byte_out = byte_in ^ SCRAMBLE_KEY;
    else                           byte_out = byte_in;
  end
endmodule

// File: rtl/fuse_boot_ctrl.sv
module fuse_boot_ctrl
  import fbc_pkg::*;
#(
  parameter int          ADDR_W       = 16,
  parameter int          DATA_W       = 8,
  parameter int          SYNC_STAGES  = 2,
  parameter logic [7:0]  SCRAMBLE_KEY = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        opt_i,
  input  logic [ADDR_W-1:0] isp_start_i,
  input  logic [ADDR_W-1:0] iap_low_i,
  input  logic              pwr_on_rst_i,
  input  logic              low_volt_i,
  input  logic              wr_req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] dump_byte_i,
  input  logic              dump_is_id_i,
  output logic              boot_isp_o,
  output logic [1:0]        region_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] dump_o
);
  logic              srst_n;
  opt_t              opt_q;
  logic [ADDR_W-1:0] isp_q;
  logic [ADDR_W-1:0] iap_q;
  logic              pwr_q;
  logic              loaded_q;
  logic              isp_present;
  logic              iap_present;
  part_e             part;

  fbc_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  fbc_opt_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst_n(srst_n), .opt_i(opt_i), .isp_i(isp_start_i),
    .iap_i(iap_low_i), .pwr_i(pwr_on_rst_i), .opt_q(opt_q), .isp_q(isp_q),
    .iap_q(iap_q), .pwr_q(pwr_q), .loaded_q(loaded_q)
  );

  fbc_region_decode #(.ADDR_W(ADDR_W)) u_dec (
    .isp_start(isp_q), .iap_low(iap_q), .addr(addr_i),
    .isp_present(isp_present), .iap_present(iap_present), .part(part)
  );

  fbc_access_gate #(.DATA_W(DATA_W), .SCRAMBLE_KEY(SCRAMBLE_KEY[DATA_W-1:0])) u_gate (
    .opt(opt_q), .low_volt(low_volt_i), .wr_req(wr_req_i),
    .byte_in(dump_byte_i), .is_id(dump_is_id_i),
    .wr_en(wr_en_o), .byte_out(dump_o)
  );

  always_comb begin
    boot_isp_o = isp_present && (opt_q.boot_any || (opt_q.boot_pwr && pwr_q));
    region_o   = part;
  end
endmodule

// File: rtl/fbc_checker.sv
module fbc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       loaded,
  input logic [4:0] opt,
  input logic       isp_present,
  input logic       iap_present,
  input logic       boot_isp_o,
  input logic [1:0] region_o,
  input logic       wr_req_i,
  input logic       low_volt_i,
  input logic       wr_en_o,
  input logic [7:0] dump_o
);
  p_erased_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded |-> (!boot_isp_o && region_o == 2'b00 && !iap_present));

  p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |=> (loaded && $stable(opt)));

  p_isp_needs_cfg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (region_o == 2'b10) |-> isp_present);

  p_iap_needs_cfg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (region_o == 2'b01) |-> iap_present);

  p_region_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    region_o != 2'b11);

  p_boot_needs_isp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    boot_isp_o |-> isp_present);

  p_wr_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (opt[2] && low_volt_i) |-> !wr_en_o);

  p_wr_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> wr_req_i);

  p_lock_ff_r10: assert property (@(posedge clk) disable iff (!rst_n)
    opt[4] |-> (dump_o == 8'hFF));
endmodule

bind fuse_boot_ctrl fbc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .loaded(loaded_q), .opt(opt_q),
  .isp_present(isp_present), .iap_present(iap_present),
  .boot_isp_o(boot_isp_o), .region_o(region_o), .wr_req_i(wr_req_i),
  .low_volt_i(low_volt_i), .wr_en_o(wr_en_o), .dump_o(dump_o)
);

// File: tb/tb_fuse_boot_ctrl.sv
module tb_fuse_boot_ctrl;
  logic        clk;
  logic        rst_n;
  logic [4:0]  opt_i;
  logic [15:0] isp_start_i, iap_low_i, addr_i;
  logic        pwr_on_rst_i, low_volt_i, wr_req_i, dump_is_id_i;
  logic [7:0]  dump_byte_i, dump_o;
  logic        boot_isp_o, wr_en_o;
  logic [1:0]  region_o;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  logic [4:0]  m_opt;
  logic [15:0] m_isp, m_iap;
  logic        m_pwr;

  fuse_boot_ctrl dut (
    .clk(clk), .rst_n(rst_n), .opt_i(opt_i), .isp_start_i(isp_start_i),
    .iap_low_i(iap_low_i), .pwr_on_rst_i(pwr_on_rst_i), .low_volt_i(low_volt_i),
    .wr_req_i(wr_req_i), .addr_i(addr_i), .dump_byte_i(dump_byte_i),
    .dump_is_id_i(dump_is_id_i), .boot_isp_o(boot_isp_o), .region_o(region_o),
    .wr_en_o(wr_en_o), .dump_o(dump_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic bit f_isp_ok(logic [15:0] s);
    return (s != 16'h0000) && (s != 16'hFFFF);
  endfunction

  function automatic logic [1:0] f_region(logic [15:0] s, logic [15:0] l, logic [15:0] a);
    int ceil;
    ceil = f_isp_ok(s) ? int'(s) : 65536;
    if (f_isp_ok(s) && a >= s) return 2'b10;
    if (l != 16'hFFFF && int'(l) < ceil && a >= l) return 2'b01;
    return 2'b00;
  endfunction

  function automatic bit f_boot(logic [4:0] o, logic [15:0] s, logic p);
    return f_isp_ok(s) && (o[1] || (o[0] && p));
  endfunction

  function automatic logic [7:0] f_dump(logic [4:0] o, logic [7:0] b, logic id);
    if (o[4]) return 8'hFF;
    if (o[3] && !id) return b ^ 8'hA5;
    return b;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h (opt=%b isp=%h iap=%h pwr=%b)",
               tag, got, exp, m_opt, m_isp, m_iap, m_pwr);
    end
  endtask

  task automatic apply_cfg(logic [4:0] o, logic [15:0] s, logic [15:0] l, logic p);
    @(negedge clk);
    rst_n = 1'b0;
    opt_i = o; isp_start_i = s; iap_low_i = l; pwr_on_rst_i = p;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    m_opt = o; m_isp = s; m_iap = l; m_pwr = p;
    // R2: disturb configuration inputs after capture
    opt_i = 5'($urandom); isp_start_i = 16'($urandom);
    iap_low_i = 16'($urandom); pwr_on_rst_i = 1'($urandom);
    @(negedge clk);
  endtask

  task automatic chk_addr(logic [15:0] a);
    logic [1:0] e;
    addr_i = a;
    #1;
    e = f_region(m_isp, m_iap, a);
    if (e == 2'b10)      chk("R3 region", 32'(region_o), 32'(e));
    else if (e == 2'b01) chk("R4 region", 32'(region_o), 32'(e));
    else                 chk("R5 region", 32'(region_o), 32'(e));
  endtask

  task automatic chk_all(int n_rand);
    bit eb;
    eb = f_boot(m_opt, m_isp, m_pwr);
    if (!f_isp_ok(m_isp) || !(m_opt[1] || m_opt[0])) chk("R8 boot", 32'(boot_isp_o), 32'(eb));
    else if (m_opt[1])                                chk("R6 boot", 32'(boot_isp_o), 32'(eb));
    else                                              chk("R7 boot", 32'(boot_isp_o), 32'(eb));
    chk("R2 boot held", 32'(boot_isp_o), 32'(eb));
    chk_addr(16'h0000); chk_addr(16'hFFFF);
    chk_addr(m_isp); chk_addr(m_isp - 16'd1);
    chk_addr(m_iap); chk_addr(m_iap - 16'd1);
    for (int i = 0; i < n_rand; i++) chk_addr(16'($urandom));
    for (int k = 0; k < 4; k++) begin
      wr_req_i = k[0]; low_volt_i = k[1];
      #1;
      chk("R9 wr_en", 32'(wr_en_o), 32'(k[0] && !(m_opt[2] && k[1])));
    end
    for (int k = 0; k < 4; k++) begin
      dump_byte_i = 8'($urandom); dump_is_id_i = k[0];
      #1;
      if (m_opt[4]) chk("R10 dump", 32'(dump_o), 32'(f_dump(m_opt, dump_byte_i, dump_is_id_i)));
      else          chk("R11 dump", 32'(dump_o), 32'(f_dump(m_opt, dump_byte_i, dump_is_id_i)));
    end
    @(negedge clk);
  endtask

  function automatic logic [15:0] pick_isp();
    int r;
    r = int'($urandom % 4);
    if (r == 0) return 16'h0000;
    if (r == 1) return 16'hFFFF;
    return 16'($urandom);
  endfunction

  initial begin : watchdog
    #(8 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd2024));
    rst_n = 1'b0; opt_i = 5'b11111; isp_start_i = 16'hE000; iap_low_i = 16'h8000;
    pwr_on_rst_i = 1'b1; low_volt_i = 1'b0; wr_req_i = 1'b0; addr_i = 16'h0;
    dump_byte_i = 8'h3C; dump_is_id_i = 1'b0;
    repeat (3) @(negedge clk);
    // R1: erased behaviour while reset is held
    chk("R1 boot", 32'(boot_isp_o), 32'h0);
    addr_i = 16'hF000; #1;
    chk("R1 region", 32'(region_o), 32'h0);
    addr_i = 16'h9000; #1;
    chk("R1 region", 32'(region_o), 32'h0);
    chk("R1 dump", 32'(dump_o), 32'h3C);

    // directed corners
    apply_cfg(5'b00001, 16'hF000, 16'hC000, 1'b1); chk_all(4); // R7 power-up
    apply_cfg(5'b00001, 16'hF000, 16'hC000, 1'b0); chk_all(4); // R7 other reset
    apply_cfg(5'b00010, 16'hF000, 16'hC000, 1'b0); chk_all(4); // R6
    apply_cfg(5'b00011, 16'h0000, 16'hC000, 1'b1); chk_all(4); // R8 no ISP (zero)
    apply_cfg(5'b00011, 16'hFFFF, 16'hC000, 1'b1); chk_all(4); // R8 no ISP (ones)
    apply_cfg(5'b00000, 16'hF000, 16'hFFFF, 1'b1); chk_all(4); // R4 no IAP
    apply_cfg(5'b00000, 16'hA000, 16'hB000, 1'b1); chk_all(4); // R4 IAP above ISP
    apply_cfg(5'b00000, 16'hA000, 16'hA000, 1'b1); chk_all(4); // R4 empty IAP
    apply_cfg(5'b00000, 16'h0000, 16'h0000, 1'b1); chk_all(4); // R4 IAP to top
    apply_cfg(5'b11000, 16'hF000, 16'hC000, 1'b1); chk_all(4); // R11 lock priority
    apply_cfg(5'b01000, 16'hF000, 16'hC000, 1'b1); chk_all(4); // R11 scramble
    apply_cfg(5'b00100, 16'hF000, 16'hC000, 1'b1); chk_all(4); // R9

    for (int n = 0; n < 40; n++) begin
      logic [15:0] s;
      logic [15:0] l;
      s = pick_isp();
      l = ($urandom % 5 == 0) ? 16'hFFFF : 16'($urandom);
      apply_cfg(5'($urandom), s, l, 1'($urandom));
      chk_all(12);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule